// File: doc/BRIEF.md
# SPI Serial SRAM Slave Controller

This block is the slave side of a serial memory port. An external SPI master selects it by pulling chip select low, shifts in an 8-bit opcode, and, for memory accesses, a 16-bit byte address, then streams data bytes into or out of an on-chip byte array. A small mode register sets how the internal address pointer moves between consecutive data bytes. The choices are a single byte per access, wrapping inside a 32-byte page, or running linearly through the whole 64K space with rollover.

The serial pins are oversampled by the local clock `clk`. SCK, CS and SI each pass through a two-flop synchroniser. Edges of SCK are detected in the `clk` domain, so SCK must run well below `clk`. The protocol pointer is always 16 bits wide. The backing store holds `2**STORE_AW` bytes, and the low pointer bits index into it.

Top module: `spi_sram_slave`

## Requirements
- R1: Raising CS ends any transaction and discards its progress. The next CS-low period begins again with a fresh opcode.
- R2: SI is sampled on rising SCK edges, most significant bit first. An access is an 8-bit opcode, a 16-bit address, then data bytes.
- R3: The opcode values are as follows. 0x03 reads memory and 0x02 writes memory. 0x05 reads the mode register, which returns the mode in bits 7:6 with zeros below. 0x01 writes the mode register from bits 7:6 of the next byte. Any other opcode is ignored until CS rises: no memory write and SO stays 0.
- R4: Mode bits 7:6 select the addressing mode. 00 is single byte, 10 is page wrap, 01 is sequential, and 11 behaves as single byte. After reset the mode is 01, so a mode read returns 0x40.
- R5: In single-byte mode, exactly one data byte is transferred after the address. Further write bytes are dropped and further read clocks give SO = 0.
- R6: In page mode, the pointer steps by one after each byte and wraps from offset 31 back to offset 0 of the same 32-byte page. The upper 11 address bits stay fixed.
- R7: In sequential mode, the pointer steps by one after each byte across page borders and rolls over from 0xFFFF to 0x0000.
- R8: Read data is driven on SO MSB first, and updates after falling SCK edges. The byte at the current pointer is presented, and the pointer advances once all eight bits have been clocked out.
- R9: A written byte enters the array only when all eight of its bits have arrived. A partial byte at CS rise is discarded.
- R10: SO is 0 whenever no read data is being shifted out: during opcode and address, in ignored or finished transfers, and while CS is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out, 0 when idle |

## Verification
The assertions assume SCK is slow enough relative to `clk` that each SCK level lasts several `clk` cycles. They also assume SI changes only while SCK is low, and CS changes only while SCK is low. Given that, each detected rising edge samples a settled bit, and pointer steps can be checked one edge later. The bench drives every SCK half period as eight `clk` cycles. It updates SI and CS only after a falling SCK edge and samples SO at its own rising SCK edge, which stays within those assumptions.

// File: rtl/spi_sram_slave.sv
module spi_sram_slave #(
  parameter int ADDR_W   = 16,
  parameter int STORE_AW = 10,
  parameter int PAGE_W   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic so
);
  localparam int DEPTH = 1 << STORE_AW;
  localparam int CW    = $clog2(ADDR_W) + 1;
  localparam logic [1:0] M_SEQ  = 2'b01;
  localparam logic [1:0] M_PAGE = 2'b10;

  typedef enum logic [2:0] {S_CMD, S_ADDR, S_RD, S_WR, S_MRD, S_MWR, S_HOLD} st_t;

  st_t               st;
  logic [2:0]        sck_q, cs_q;
  logic [1:0]        si_q;
  logic [CW-1:0]     bitcnt;
  logic [7:0]        sh, obyte;
  logic [ADDR_W-1:0] ptr;
  logic [1:0]        mode;
  logic              so_r, rd_op;
  logic [7:0]        mem [DEPTH];

  wire        si_s     = si_q[1];
  wire        cs_hi    = cs_q[1];
  wire        rise     = sck_q[1] & ~sck_q[2];
  wire        fall     = ~sck_q[1] & sck_q[2];
  wire [7:0]  in_byte  = {sh[6:0], si_s};
  wire        byte_end = (bitcnt[2:0] == 3'd7);
  wire        reading  = (st == S_RD) || (st == S_MRD);
  wire [1:0]  eff      = (mode == 2'b11) ? 2'b00 : mode;
  wire [7:0]  rd_byte  = (st == S_MRD) ? {mode, 6'b0} : mem[ptr[STORE_AW-1:0]];
  wire        we       = rst_n && !cs_hi && rise && st == S_WR && byte_end;

  assign so = so_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q  <= '0;
      cs_q   <= '1;
      si_q   <= '0;
      st     <= S_CMD;
      bitcnt <= '0;
      sh     <= '0;
      obyte  <= '0;
      ptr    <= '0;
      mode   <= M_SEQ;
      so_r   <= 1'b0;
      rd_op  <= 1'b0;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      cs_q  <= {cs_q[1:0], cs_n};
      si_q  <= {si_q[0], si};
      if (cs_hi) begin
        st     <= S_CMD;
        bitcnt <= '0;
        so_r   <= 1'b0;
      end else if (rise) begin
        sh     <= in_byte;
        bitcnt <= bitcnt + 1'b1;
        case (st)
          S_CMD: if (byte_end) begin
            bitcnt <= '0;
            case (in_byte)
              8'h03:   begin st <= S_ADDR; rd_op <= 1'b1; end
              8'h02:   begin st <= S_ADDR; rd_op <= 1'b0; end
              8'h05:   st <= S_MRD;
              8'h01:   st <= S_MWR;
              default: st <= S_HOLD;
            endcase
          end
          S_ADDR: begin
            ptr <= {ptr[ADDR_W-2:0], si_s};
            if (bitcnt == CW'(ADDR_W - 1)) begin
              bitcnt <= '0;
              st     <= rd_op ? S_RD : S_WR;
            end
          end
          S_RD, S_WR: if (byte_end) begin
            bitcnt <= '0;
            case (eff)
              M_PAGE:  ptr <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
              M_SEQ:   ptr <= ptr + 1'b1;
              default: begin st <= S_HOLD; so_r <= 1'b0; end
            endcase
          end
          S_MRD: if (byte_end) begin
            bitcnt <= '0;
            st     <= S_HOLD;
            so_r   <= 1'b0;
          end
          S_MWR: if (byte_end) begin
            bitcnt <= '0;
            mode   <= in_byte[7:6];
            st     <= S_HOLD;
          end
          default: bitcnt <= '0;
        endcase
      end else if (fall) begin
        if (reading) begin
          if (bitcnt == '0) begin
            obyte <= rd_byte;
            so_r  <= rd_byte[7];
          end else begin
            so_r <= obyte[~bitcnt[2:0]];
          end
        end else begin
          so_r <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[ptr[STORE_AW-1:0]] <= in_byte;
  end

  a_r1_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> (st == S_CMD && bitcnt == '0 && !so));

  a_r4_reset_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> mode == M_SEQ);

  a_r5_byte_single: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_hi && rise && (st == S_RD || st == S_WR) && byte_end && eff == 2'b00)
      |=> (st == S_HOLD || cs_hi));

  a_r6_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_hi && rise && (st == S_RD || st == S_WR) && byte_end && eff == M_PAGE)
      |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]) &&
           ptr[PAGE_W-1:0] == $past(ptr[PAGE_W-1:0]) + 1'b1));

  a_r7_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_hi && rise && (st == S_RD || st == S_WR) && byte_end && eff == M_SEQ)
      |=> ptr == $past(ptr) + 1'b1);

  a_r10_so_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CMD || st == S_ADDR || st == S_WR || st == S_MWR || st == S_HOLD) |-> !so);
endmodule

// File: tb/sim_spi_sram_slave.sv
module sim_spi_sram_slave;
  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0;
  wire  so;
  int   checks = 0, failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       cap = 0;
  string      quiet_tag = "R10";
  logic [7:0] rx = 0;
  int         nb = 0;

  always #2 clk = ~clk;

  spi_sram_slave u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so));

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    si = b; wait_clk(8); sck = 1; wait_clk(8); sck = 0;
  endtask

  task automatic send(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
  endtask

  task automatic recv(input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    cap = 1; send(8'h00); cap = 0;
  endtask

  task automatic start(); cs_n = 0; wait_clk(8); endtask
  task automatic stop();  wait_clk(8); cs_n = 1; wait_clk(10); endtask

  task automatic op_addr(input logic [7:0] op, input logic [15:0] a);
    start(); send(op); send(a[15:8]); send(a[7:0]);
  endtask

  task automatic set_mode(input logic [7:0] m);
    start(); send(8'h01); send(m); stop();
  endtask

  always @(posedge sck) begin
    if (cap) begin
      rx = {rx[6:0], so};
      nb++;
      if (nb == 8) begin
        logic [7:0] e;
        string t;
        nb = 0;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rx === e, t, rx, e);
      end
    end else if (!cs_n) begin
      chk(so === 1'b0, quiet_tag, {7'b0, so}, 8'h00);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog timeout");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_clk(6); rst_n = 1; wait_clk(4);
    chk(so === 1'b0, "R10 reset", {7'b0, so}, 8'h00);
    // R4 reset mode reads back as sequential
    start(); send(8'h05); recv(8'h40, "R4 reset mode"); stop();
    // R2 R7 R8 sequential write then read
    op_addr(8'h02, 16'h0010); send(8'hA1); send(8'h5C); send(8'h3E); send(8'h97); stop();
    op_addr(8'h03, 16'h0010);
    recv(8'hA1, "R2 seq"); recv(8'h5C, "R8 seq"); recv(8'h3E, "R7 seq"); recv(8'h97, "R8 seq"); stop();
    // R7 rollover
    op_addr(8'h02, 16'hFFFE); send(8'h11); send(8'h22); send(8'h33); stop();
    op_addr(8'h03, 16'hFFFF); recv(8'h22, "R7 top"); recv(8'h33, "R7 rollover"); stop();
    // R6 page wrap
    set_mode(8'h80);
    start(); send(8'h05); recv(8'h80, "R4 page mode read"); stop();
    op_addr(8'h02, 16'h003E); send(8'hC0); send(8'hC1); send(8'hC2); send(8'hC3); stop();
    op_addr(8'h03, 16'h0020); recv(8'hC2, "R6 wrap write"); recv(8'hC3, "R6 wrap write"); stop();
    op_addr(8'h03, 16'h003F); recv(8'hC1, "R6 read wrap"); recv(8'hC2, "R6 read wrap"); stop();
    // R5 byte mode
    set_mode(8'h40);
    op_addr(8'h02, 16'h0050); send(8'h5A); send(8'h6B); stop();
    set_mode(8'h00);
    op_addr(8'h02, 16'h0050); send(8'hB0); send(8'hB1); stop();
    quiet_tag = "R5";
    op_addr(8'h03, 16'h0050); recv(8'hB0, "R5 byte read"); send(8'h00); stop();
    quiet_tag = "R10";
    set_mode(8'h40);
    op_addr(8'h03, 16'h0050); recv(8'hB0, "R5 single"); recv(8'h6B, "R5 second untouched"); stop();
    // R4 mode 11 acts as byte mode
    set_mode(8'hC0);
    start(); send(8'h05); recv(8'hC0, "R4 mode11 read"); stop();
    op_addr(8'h02, 16'h0050); send(8'hC5); send(8'hC6); stop();
    set_mode(8'h40);
    op_addr(8'h03, 16'h0050); recv(8'hC5, "R4 mode11"); recv(8'h6B, "R4 mode11 single"); stop();
    // R3 unknown opcode ignored
    quiet_tag = "R3";
    start(); send(8'hAB); send(8'h00); send(8'h50); send(8'hEE); send(8'hFF); stop();
    quiet_tag = "R10";
    op_addr(8'h03, 16'h0050); recv(8'hC5, "R3 no write"); stop();
    // R9 partial byte discarded
    op_addr(8'h02, 16'h0060); send(8'h77); send(8'h66); stop();
    op_addr(8'h02, 16'h0060); send(8'h99); for (int i = 0; i < 5; i++) bit_out(1'b1); stop();
    op_addr(8'h03, 16'h0060); recv(8'h99, "R9 full"); recv(8'h66, "R9 partial"); stop();
    // R1 abort mid address
    start(); send(8'h02); send(8'h00); stop();
    start(); send(8'h05); recv(8'h40, "R1 fresh opcode"); stop();
    chk(exp_q.size() == 0, "R8 queue drained", 8'(exp_q.size()), 8'h00);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule